// File: doc/BRIEF.md
# Address Area Decoder with Chip Selects

This block sorts every bus access into one of eight equal address areas, taken from the top three bits of a 24-bit address, so each area spans 2 MB. It decides whether the access lands in on-chip ROM, on-chip RAM, the internal I/O register window or external space. Only when the access goes external does it pull the chip select of that area low. The ROM sits at the bottom of area 0. The RAM and I/O windows sit near the top of area 7. Each window has a base and a size set by parameters.

A mode input chooses whether on-chip ROM is mapped at all. A RAM-enable bit can hand the RAM window back to external space. Each chip-select pin has its own direction bit, held in a small register inside the block. A pin drives only while its bit is 1, and reset clears every bit, so every pin starts as an input. The block also reports the bus-interface type of the area being accessed, basic or burst. Only area 0 can be set to burst.

Top module: `area_cs_decoder`

## Requirements
- R1: For an external access, the area index is address bits [23:21]. `csN` bit i is 0 only for the decoded area i and all other bits are 1, so at most one chip select is low.
- R2: While `busStrobe` is 0, `csN` is all ones, `isExternal` is 0, `accTarget` is 0 and `areaBurst` is 0.
- R3: With `romExtMode`=1, addresses 0x000000 to ROM_SIZE-1 (default 0x07FFFF) give `accTarget`=1 (ROM) and no chip select. The rest of area 0 is external and drives `csN[0]` low.
- R4: With `romExtMode`=0, all of area 0 is external and drives `csN[0]` low.
- R5: Areas 1 to 6 (0x200000 to 0xDFFFFF) are always external and drive their own chip select low.
- R6: The I/O window RAM-independent, default 0xFFF000 to 0xFFFFFF, always gives `accTarget`=3 (I/O) and no chip select.
- R7: With `ramEnable`=1, the RAM window (default 0xFF0000 to 0xFF7FFF) gives `accTarget`=2 (RAM) and no chip select. With `ramEnable`=0 the same addresses are external and drive `csN[7]` low.
- R8: The part of area 7 outside the internal windows is external and drives `csN[7]` low.
- R9: `areaBurst` is 1 only for a strobed access to area 0 while `area0Burst` is 1. Areas 1 to 7 always report 0 (basic interface).
- R10: When `dirWe` is 1 at a rising clock edge, `dirData` is loaded into the direction register. `csOe[i]` equals direction bit i from the next cycle on, and the register holds its value while `dirWe` is 0.
- R11: After reset, every direction bit is 0, so `csOe` is all zeros.
- R12: `isExternal` is 1 exactly when a strobed access has `accTarget`=0 (external). Target codes are 0 external, 1 ROM, 2 RAM, 3 I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the direction register |
| rstN | input | 1 | Active-low reset, clears direction bits |
| busAddr | input | 24 | Access address |
| busStrobe | input | 1 | Access in progress |
| romExtMode | input | 1 | 1: on-chip ROM mapped in area 0 |
| ramEnable | input | 1 | 1: RAM window is internal |
| area0Burst | input | 1 | 1: area 0 uses the burst interface |
| dirWe | input | 1 | Direction register write enable |
| dirData | input | 8 | Direction register write data |
| csN | output | 8 | Active-low chip select per area |
| csOe | output | 8 | Output enable per chip-select pin |
| isExternal | output | 1 | Access targets external space |
| accTarget | output | 2 | 0 ext, 1 ROM, 2 RAM, 3 I/O |
| areaBurst | output | 1 | Accessed area uses the burst interface |

## Verification
A wrong window bound shows up on the first access at that edge. The target code and the chip select flip together within the same cycle. For that reason the vector table probes both sides of every window edge and every area edge. A stale RAM-enable or mode decision shows as a chip select low on an internal address, or high on an external one. A corrupted direction bit shows at `csOe` one cycle after the write, or directly after reset. The bench checks both of these points.

// File: rtl/area_cs_pkg.sv
package area_cs_pkg;
  localparam int NUM_AREAS  = 8;
  localparam int AREA_SEL_W = $clog2(NUM_AREAS);

  typedef enum logic [1:0] {
    TGT_EXT = 2'd0,
    TGT_ROM = 2'd1,
    TGT_RAM = 2'd2,
    TGT_IO  = 2'd3
  } target_e;

  typedef struct packed {
    logic                 active;
    logic                 romMode;
    logic                 ramOn;
    logic                 burstSel;
    logic [NUM_AREAS-1:0] dirBits;
  } ctl_strobes_t;
endpackage

// File: rtl/area_cs_ctrl.sv
module area_cs_ctrl
  import area_cs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busStrobe,
  input  logic                 romExtMode,
  input  logic                 ramEnable,
  input  logic                 area0Burst,
  input  logic                 dirWe,
  input  logic [NUM_AREAS-1:0] dirData,
  output ctl_strobes_t         ctl
);
  logic [NUM_AREAS-1:0] dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dirQ <= '0;
    else if (dirWe) dirQ <= dirData;
  end

  always_comb begin
    ctl.active   = busStrobe;
    ctl.romMode  = romExtMode;
    ctl.ramOn    = ramEnable;
    ctl.burstSel = area0Burst;
    ctl.dirBits  = dirQ;
  end

  // R10: a write lands one cycle later
  p_dir_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    dirWe |=> dirQ == $past(dirData));
  // R10: without a write the register holds
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dirWe |=> $stable(dirQ));
endmodule

// File: rtl/area_cs_datapath.sv
module area_cs_datapath
  import area_cs_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int unsigned ROM_SIZE = 32'h0008_0000,
  parameter int unsigned RAM_BASE = 32'h00FF_0000,
  parameter int unsigned RAM_SIZE = 32'h0000_8000,
  parameter int unsigned IO_BASE  = 32'h00FF_F000,
  parameter int unsigned IO_SIZE  = 32'h0000_1000
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  ctl_strobes_t         ctl,
  output logic [NUM_AREAS-1:0] csN,
  output logic [NUM_AREAS-1:0] csOe,
  output logic                 isExternal,
  output target_e              accTarget,
  output logic                 areaBurst
);
  localparam int unsigned RAM_END = RAM_BASE + RAM_SIZE;
  localparam int unsigned IO_END  = IO_BASE + IO_SIZE;
  localparam int          SEL_LO  = ADDR_W - AREA_SEL_W;

  logic [31:0]           addrW;
  logic [AREA_SEL_W-1:0] areaIdx;
  logic                  hitRom, hitRam, hitIo;
  target_e               tgt;
  logic                  extHit;

  assign addrW   = 32'(addr);
  assign areaIdx = addr[ADDR_W-1:SEL_LO];

  always_comb begin
    hitRom = ctl.romMode && (addrW < ROM_SIZE);
    hitRam = ctl.ramOn && (addrW >= RAM_BASE) && (addrW < RAM_END);
    hitIo  = (addrW >= IO_BASE) && (addrW < IO_END);
    if (hitIo)       tgt = TGT_IO;
    else if (hitRam) tgt = TGT_RAM;
    else if (hitRom) tgt = TGT_ROM;
    else             tgt = TGT_EXT;
  end

  assign extHit     = ctl.active && (tgt == TGT_EXT);
  assign isExternal = extHit;
  assign accTarget  = ctl.active ? tgt : TGT_EXT;
  assign areaBurst  = ctl.active && ctl.burstSel && (areaIdx == '0);

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
    assign csN[i]  = ~(extHit && (areaIdx == AREA_SEL_W'(i)));
    assign csOe[i] = ctl.dirBits[i];
  end

  // R1: never more than one chip select low
  p_one_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);
  // R2: idle bus keeps every select high
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (csN == '1) && !isExternal);
  // R12: internal target never raises a chip select
  p_int_no_cs_r12: assert property (@(posedge clk) disable iff (!rstN)
    (accTarget != TGT_EXT) |-> (csN == '1));
  // R9: burst flag only for area 0
  p_burst_area0_r9: assert property (@(posedge clk) disable iff (!rstN)
    areaBurst |-> (addr[ADDR_W-1:SEL_LO] == '0) && ctl.active);
endmodule

// File: rtl/area_cs_decoder.sv
module area_cs_decoder
  import area_cs_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int unsigned ROM_SIZE = 32'h0008_0000,
  parameter int unsigned RAM_BASE = 32'h00FF_0000,
  parameter int unsigned RAM_SIZE = 32'h0000_8000,
  parameter int unsigned IO_BASE  = 32'h00FF_F000,
  parameter int unsigned IO_SIZE  = 32'h0000_1000
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busStrobe,
  input  logic                 romExtMode,
  input  logic                 ramEnable,
  input  logic                 area0Burst,
  input  logic                 dirWe,
  input  logic [NUM_AREAS-1:0] dirData,
  output logic [NUM_AREAS-1:0] csN,
  output logic [NUM_AREAS-1:0] csOe,
  output logic                 isExternal,
  output logic [1:0]           accTarget,
  output logic                 areaBurst
);
  ctl_strobes_t ctl;
  target_e      tgt;

  area_cs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .romExtMode(romExtMode),
    .ramEnable(ramEnable), .area0Burst(area0Burst), .dirWe(dirWe),
    .dirData(dirData), .ctl(ctl)
  );

  area_cs_datapath #(
    .ADDR_W(ADDR_W), .ROM_SIZE(ROM_SIZE), .RAM_BASE(RAM_BASE),
    .RAM_SIZE(RAM_SIZE), .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(busAddr), .ctl(ctl), .csN(csN),
    .csOe(csOe), .isExternal(isExternal), .accTarget(tgt),
    .areaBurst(areaBurst)
  );

  assign accTarget = tgt;
endmodule

// File: tb/area_cs_decoder_tb.sv
module area_cs_decoder_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [23:0] busAddr = '0;
  logic        busStrobe = 0, romExtMode = 1, ramEnable = 1, area0Burst = 0;
  logic        dirWe = 0;
  logic [7:0]  dirData = '0;
  logic [7:0]  csN, csOe;
  logic        isExternal, areaBurst;
  logic [1:0]  accTarget;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  area_cs_decoder u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busStrobe(busStrobe),
    .romExtMode(romExtMode), .ramEnable(ramEnable), .area0Burst(area0Burst),
    .dirWe(dirWe), .dirData(dirData), .csN(csN), .csOe(csOe),
    .isExternal(isExternal), .accTarget(accTarget), .areaBurst(areaBurst)
  );

  // {addr, strobe, romMode, ramEn, burst, expCsN, expExt, expTgt, expBurst}
  localparam int NV = 23;
  localparam logic [39:0] VEC [NV] = '{
    {24'h000000, 4'b1100, 8'hFF, 1'b0, 2'd1, 1'b0}, // R3 ROM bottom
    {24'h07FFFF, 4'b1100, 8'hFF, 1'b0, 2'd1, 1'b0}, // R3 ROM top
    {24'h080000, 4'b1100, 8'hFE, 1'b1, 2'd0, 1'b0}, // R3 past ROM
    {24'h080000, 4'b1101, 8'hFE, 1'b1, 2'd0, 1'b1}, // R9 burst area 0
    {24'h000000, 4'b1000, 8'hFE, 1'b1, 2'd0, 1'b0}, // R4 ROM unmapped
    {24'h1FFFFF, 4'b1100, 8'hFE, 1'b1, 2'd0, 1'b0}, // R1 area 0 top
    {24'h200000, 4'b1101, 8'hFD, 1'b1, 2'd0, 1'b0}, // R5 R9 area 1
    {24'h5A5A5A, 4'b1100, 8'hFB, 1'b1, 2'd0, 1'b0}, // R5 area 2
    {24'h600000, 4'b1100, 8'hF7, 1'b1, 2'd0, 1'b0}, // R5 area 3
    {24'h9FFFFF, 4'b1100, 8'hEF, 1'b1, 2'd0, 1'b0}, // R5 area 4
    {24'hA00000, 4'b1100, 8'hDF, 1'b1, 2'd0, 1'b0}, // R5 area 5
    {24'hDFFFFF, 4'b1100, 8'hBF, 1'b1, 2'd0, 1'b0}, // R5 area 6
    {24'hE00000, 4'b1101, 8'h7F, 1'b1, 2'd0, 1'b0}, // R8 R9 area 7
    {24'hFEFFFF, 4'b1110, 8'h7F, 1'b1, 2'd0, 1'b0}, // R8 below RAM
    {24'hFF0000, 4'b1110, 8'hFF, 1'b0, 2'd2, 1'b0}, // R7 RAM base
    {24'hFF7FFF, 4'b1110, 8'hFF, 1'b0, 2'd2, 1'b0}, // R7 RAM top
    {24'hFF0000, 4'b1100, 8'h7F, 1'b1, 2'd0, 1'b0}, // R7 RAM disabled
    {24'hFF8000, 4'b1110, 8'h7F, 1'b1, 2'd0, 1'b0}, // R8 past RAM
    {24'hFFEFFF, 4'b1110, 8'h7F, 1'b1, 2'd0, 1'b0}, // R8 below I/O
    {24'hFFF000, 4'b1110, 8'hFF, 1'b0, 2'd3, 1'b0}, // R6 I/O base
    {24'hFFFFFF, 4'b1100, 8'hFF, 1'b0, 2'd3, 1'b0}, // R6 I/O top
    {24'hFFF000, 4'b0110, 8'hFF, 1'b0, 2'd0, 1'b0}, // R2 idle
    {24'h080000, 4'b0111, 8'hFF, 1'b0, 2'd0, 1'b0}  // R2 idle burst cfg
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R11 reset oe", 32'(csOe), 32'h00);
    chk("R2 reset idle cs", 32'(csN), 32'hFF);
    @(negedge clk) rstN = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {busAddr, busStrobe, romExtMode, ramEnable, area0Burst} = VEC[i][39:12];
      #1;
      chk($sformatf("R1/vec%0d csN", i), 32'(csN), 32'(VEC[i][11:4]));
      chk($sformatf("R12/vec%0d ext", i), 32'(isExternal), 32'(VEC[i][3]));
      chk($sformatf("R12/vec%0d tgt", i), 32'(accTarget), 32'(VEC[i][2:1]));
      chk($sformatf("R9/vec%0d burst", i), 32'(areaBurst), 32'(VEC[i][0]));
    end

    // R10 direction writes, visible next cycle
    @(negedge clk) begin dirWe = 1; dirData = 8'hA5; end
    #1 chk("R10 before edge", 32'(csOe), 32'h00);
    @(negedge clk) begin dirWe = 0; dirData = 8'h3C; end
    #1 chk("R10 load", 32'(csOe), 32'hA5);
    @(negedge clk) #1 chk("R10 hold", 32'(csOe), 32'hA5);
    @(negedge clk) begin dirWe = 1; dirData = 8'hFF; end
    @(negedge clk) begin dirWe = 0; end
    #1 chk("R10 all on", 32'(csOe), 32'hFF);
    // chip select still decoded with pins enabled
    busAddr = 24'h600000; busStrobe = 1; #1;
    chk("R5 cs with oe", 32'(csN), 32'hF7);
    // R11 reset clears the direction register again
    @(negedge clk) rstN = 0;
    #1 chk("R11 reclear", 32'(csOe), 32'h00);
    @(negedge clk) rstN = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule